// File: doc/BRIEF.md
# SPI Flash Sector Erase Sequencer

This block erases a single 4 KiB sector of a serial NOR flash. A host raises `req` for one cycle with a 24-bit byte address. The block first checks that the address lies on a sector boundary. If it does not, the block answers at once with an error code and drives nothing on the serial lines.

For an aligned address the block runs three kinds of chip-select frame, one after another. The first is a lone write-enable byte. The second is the erase opcode followed by the address, most significant byte first. The third kind is a status read, which is repeated until the flash reports that its internal operation has finished. The host sees `busy` while this runs. At the end it sees a one-cycle `done` with `err_code` valid in that same cycle.

The serial side uses SPI mode 0. `spi_sclk` idles low and is a parameterised divide of the system clock. Data goes out MSB first and changes only on the falling clock edge, while the flash's reply is captured on the rising edge. Between two frames, chip-select stays high for at least `CS_GAP` system clocks.

Top module: `spi_sector_eraser`

## Requirements
- R1: A request whose address has any of bits 11:0 set is answered in the next cycle with `done`=1 and `err_code`=1, `busy` stays 0, and `spi_cs_n` never goes low for it.
- R2: For an aligned request, the first frame contains exactly one byte, 0x06.
- R3: The second frame contains exactly four bytes: 0x20, then address bits 23:16, then 15:8, then 7:0.
- R4: Every following frame is a status poll of exactly two bytes: 0x05 sent, then one byte read on `spi_miso`. Polls repeat while bit 0 of the byte read is 1, and the other status bits have no effect.
- R5: `done` for an aligned request comes only after a poll that read bit 0 as 0. It carries `err_code`=0, and no further frame follows.
- R6: SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, bytes are MSB first, and `spi_mosi` holds steady while `spi_sclk` is high.
- R7: Between two consecutive frames, `spi_cs_n` stays high for at least `CS_GAP` system clocks.
- R8: A request raised while `busy` is 1 is ignored. The running erase keeps its address, and no extra `done` or error appears.
- R9: `done` is high for exactly one cycle, and `busy` is 0 in that cycle. `busy` is 1 from the cycle after an aligned request is accepted until the `done` cycle.
- R10: Reset, even in the middle of an erase, leaves `spi_cs_n`=1, `spi_sclk`=0, `busy`=0, `done`=0 and `err_code`=0, and the next request runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start pulse, sampled when not busy |
| req_addr | input | 24 | Byte address of the sector to erase |
| busy | output | 1 | Erase sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 = success, 1 = unaligned address; valid with `done` |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bound checker checks a set of properties on every cycle:
- the immediate rejection of unaligned requests and the quiet chip-select that goes with it;
- the idle-low serial clock, and data holding steady while that clock is high;
- the minimum chip-select gap, counted against a counter;
- the one-cycle `done` and its exclusion from `busy`;
- the absence of any error caused by a request made while busy.

Only the bench's flash model can show the byte content and order of each frame, the number of status polls, and that a set bit 1 in the status byte does not prolong polling. The same holds for the erase address surviving a request that arrives mid-sequence.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    localparam int ADDR_W      = 24;
    localparam int ADDR_BYTES  = ADDR_W / 8;
    localparam int SECTOR_BITS = 12;
    localparam int IDX_W       = $clog2(ADDR_BYTES + 1);
    localparam int ERR_W       = 2;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] FILL_BYTE = 8'h00;

    localparam logic [ERR_W-1:0] ERR_NONE      = ERR_W'(0);
    localparam logic [ERR_W-1:0] ERR_UNALIGNED = ERR_W'(1);

    typedef enum logic [1:0] {
        FR_WREN,
        FR_ERASE,
        FR_POLL
    } frame_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_GAP
    } seq_e;

    typedef struct packed {
        seq_e                state;
        frame_e              frame;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          status;
    } ctx_t;

    function automatic logic [IDX_W-1:0] last_idx(frame_e f);
        case (f)
            FR_WREN:  last_idx = '0;
            FR_ERASE: last_idx = IDX_W'(ADDR_BYTES);
            FR_POLL:  last_idx = IDX_W'(1);
            default:  last_idx = '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_erase_align_chk.sv
module spi_erase_align_chk
    import spi_erase_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned
);
    assign aligned = (addr[SECTOR_BITS-1:0] == '0);
endmodule

// File: rtl/spi_erase_byte_sel.sv
module spi_erase_byte_sel
    import spi_erase_pkg::*;
(
    input  frame_e            frame,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        tx_byte
);
    logic [7:0]       addr_byte [ADDR_BYTES];
    logic [IDX_W-1:0] sel;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
        assign addr_byte[g] = addr[ADDR_W-1-8*g -: 8];
    end

    assign sel = idx - IDX_W'(1);

    always_comb begin
        tx_byte = FILL_BYTE;
        case (frame)
            FR_WREN:  tx_byte = OP_WREN;
            FR_ERASE: begin
                if (idx == '0)
                    tx_byte = OP_ERASE;
                else if (int'(idx) <= ADDR_BYTES)
                    tx_byte = addr_byte[sel];
            end
            FR_POLL:  tx_byte = (idx == '0) ? OP_STATUS : FILL_BYTE;
            default:  tx_byte = FILL_BYTE;
        endcase
    end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic             active;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;
    logic             sclk_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    sh_tx   <= tx_byte;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    sh_rx  <= {sh_rx[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        sh_tx   <= {sh_tx[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = sh_tx[7];
    assign rx_byte   = sh_rx;
    assign byte_done = done_q;
endmodule

// File: rtl/spi_sector_eraser.sv
module spi_sector_eraser
    import spi_erase_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int CS_GAP  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [ERR_W-1:0]  err_code,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

    ctx_t             ctx_q;
    logic [GAP_W-1:0] gap_cnt;
    logic             cs_n_q;
    logic             done_q;
    logic [ERR_W-1:0] err_q;

    logic             aligned;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             eng_start;
    logic             eng_done;

    spi_erase_align_chk u_align (
        .addr    (req_addr),
        .aligned (aligned)
    );

    spi_erase_byte_sel u_bytesel (
        .frame   (ctx_q.frame),
        .idx     (ctx_q.idx),
        .addr    (ctx_q.addr),
        .tx_byte (tx_byte)
    );

    assign eng_start = (ctx_q.state == S_LOAD);

    spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .byte_done (eng_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q   <= '{state: S_IDLE, frame: FR_WREN, idx: '0, addr: '0, status: '0};
            gap_cnt <= '0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            case (ctx_q.state)
                S_IDLE: begin
                    if (req) begin
                        if (!aligned) begin
                            done_q <= 1'b1;
                            err_q  <= ERR_UNALIGNED;
                        end else begin
                            ctx_q.addr  <= req_addr;
                            ctx_q.frame <= FR_WREN;
                            ctx_q.idx   <= '0;
                            ctx_q.state <= S_LOAD;
                            cs_n_q      <= 1'b0;
                        end
                    end
                end
                S_LOAD: ctx_q.state <= S_SHIFT;
                S_SHIFT: begin
                    if (eng_done) begin
                        if (ctx_q.idx == last_idx(ctx_q.frame)) begin
                            cs_n_q      <= 1'b1;
                            gap_cnt     <= '0;
                            ctx_q.state <= S_GAP;
                            if (ctx_q.frame == FR_POLL)
                                ctx_q.status <= rx_byte;
                        end else begin
                            ctx_q.idx   <= ctx_q.idx + IDX_W'(1);
                            ctx_q.state <= S_LOAD;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        ctx_q.idx <= '0;
                        case (ctx_q.frame)
                            FR_WREN: begin
                                ctx_q.frame <= FR_ERASE;
                                ctx_q.state <= S_LOAD;
                                cs_n_q      <= 1'b0;
                            end
                            FR_ERASE: begin
                                ctx_q.frame <= FR_POLL;
                                ctx_q.state <= S_LOAD;
                                cs_n_q      <= 1'b0;
                            end
                            default: begin
                                if (ctx_q.status[0]) begin
                                    ctx_q.state <= S_LOAD;
                                    cs_n_q      <= 1'b0;
                                end else begin
                                    ctx_q.state <= S_IDLE;
                                    done_q      <= 1'b1;
                                    err_q       <= ERR_NONE;
                                end
                            end
                        endcase
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: ctx_q.state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (ctx_q.state != S_IDLE);
    assign done     = done_q;
    assign err_code = err_q;
    assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_sector_eraser_chk.sv
module spi_sector_eraser_chk
    import spi_erase_pkg::*;
#(
    parameter int CS_GAP = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              busy,
    input logic              done,
    input logic [ERR_W-1:0]  err_code,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi
);
    localparam int HC_W = $clog2(CS_GAP + 1);
    localparam logic [HC_W-1:0] HC_MAX = HC_W'(CS_GAP);

    logic [HC_W-1:0] hi_cnt;
    logic            seen_frame;
    logic            bad_req;

    assign bad_req = req && !busy && (req_addr[SECTOR_BITS-1:0] != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (!spi_cs_n) begin
                hi_cnt     <= '0;
                seen_frame <= 1'b1;
            end else if (hi_cnt != HC_MAX) begin
                hi_cnt <= hi_cnt + HC_W'(1);
            end
        end
    end

    AST_UNALIGNED_REJECT: assert property (@(posedge clk) disable iff (rst) bad_req |=> (done && err_code == ERR_UNALIGNED && !busy)); // R1
    AST_UNALIGNED_QUIET: assert property (@(posedge clk) disable iff (rst) bad_req |=> spi_cs_n); // R1
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> !spi_sclk); // R6
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst) spi_sclk |-> $stable(spi_mosi)); // R6
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst) ($fell(spi_cs_n) && seen_frame) |-> (hi_cnt >= HC_MAX)); // R7
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst) (req && busy) |=> !(done && err_code != ERR_NONE)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R9
    AST_ERASE_OK_CODE: assert property (@(posedge clk) disable iff (rst) (done && $past(busy)) |-> (err_code == ERR_NONE && spi_cs_n)); // R5
endmodule

bind spi_sector_eraser spi_sector_eraser_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_addr (req_addr),
    .busy     (busy),
    .done     (done),
    .err_code (err_code),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi)
);

// File: tb/spi_sector_eraser_tb.sv
module spi_sector_eraser_tb;
    localparam int CLK_DIV = 2;
    localparam int CS_GAP  = 4;
    localparam int WAIT_LIMIT = 20000;
    localparam int NV = 9;

    // {addr[23:0], polls[7:0], expected err[1:0]}
    localparam logic [33:0] VEC [NV] = '{
        {24'h000000, 8'd0, 2'd0},
        {24'h123000, 8'd2, 2'd0},
        {24'hFFF000, 8'd5, 2'd0},
        {24'hA5C000, 8'd1, 2'd0},
        {24'h000001, 8'd0, 2'd1},
        {24'h123800, 8'd0, 2'd1},
        {24'hFFFFFF, 8'd0, 2'd1},
        {24'h000FFF, 8'd0, 2'd1},
        {24'h001000, 8'd3, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [23:0] req_addr = '0;
    logic        busy, done, spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [1:0]  err_code;

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;

    spi_sector_eraser #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
        .busy(busy), .done(done), .err_code(err_code),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #10 clk = ~clk;

    // ---- flash model and bus monitor, sampled at the falling system clock edge
    int         log_epoch = 0;
    int         poll_budget = 0;
    int         seen_epoch = -1;
    int         polls_left;
    int         fr_cnt, cur_fr, bitc, hi_cnt, min_gap, mosi_bad, done_cnt;
    int         fr_len [16];
    logic [7:0] fr_byte [16][4];
    logic [7:0] cur;
    logic       prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;

    function automatic logic [7:0] status_now(int left);
        return (left > 0) ? 8'h03 : 8'h02;
    endfunction

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (seen_epoch != log_epoch) begin
            seen_epoch = log_epoch;
            polls_left = poll_budget;
            fr_cnt = 0; cur_fr = 0; bitc = 0; hi_cnt = 0;
            min_gap = 1000; mosi_bad = 0; done_cnt = 0;
            for (int i = 0; i < 16; i++) begin
                fr_len[i] = 0;
                for (int j = 0; j < 4; j++) fr_byte[i][j] = 8'h00;
            end
        end
        if (done) done_cnt++;
        if (prev_cs && !spi_cs_n) begin
            if (fr_cnt > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
            cur_fr = fr_cnt;
            fr_cnt++;
            bitc = 0;
            spi_miso = 1'b0;
        end
        if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
        if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) mosi_bad++;
        if (!spi_cs_n && !prev_sclk && spi_sclk) begin
            cur = {cur[6:0], spi_mosi};
            bitc++;
            if (bitc % 8 == 0 && cur_fr < 16 && bitc / 8 <= 4)
                fr_byte[cur_fr][bitc/8-1] = cur;
        end
        if (!spi_cs_n && prev_sclk && !spi_sclk) begin
            if (cur_fr < 16 && fr_byte[cur_fr][0] == 8'h05 && bitc >= 8 && bitc < 16)
                spi_miso = status_now(polls_left)[15-bitc];
        end
        if (!prev_cs && spi_cs_n) begin
            if (cur_fr < 16) begin
                fr_len[cur_fr] = bitc / 8;
                if (fr_byte[cur_fr][0] == 8'h05 && polls_left > 0) polls_left--;
            end
        end
        prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
    end

    // ---- checking helpers
    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [23:0] a);
        @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < WAIT_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_frames(input logic [23:0] a, input int polls);
        int bad_polls = 0;
        chk(fr_cnt == polls + 3, "R4", "frame count", fr_cnt, polls + 3);
        chk(fr_len[0] == 1 && fr_byte[0][0] == 8'h06, "R2", "write-enable frame", {fr_len[0], fr_byte[0][0]}, 32'h106);
        chk(fr_len[1] == 4, "R3", "erase frame length", fr_len[1], 4);
        chk({fr_byte[1][0], fr_byte[1][1], fr_byte[1][2], fr_byte[1][3]} == {8'h20, a},
            "R3", "erase frame bytes", {fr_byte[1][0], fr_byte[1][1], fr_byte[1][2], fr_byte[1][3]}, {8'h20, a});
        for (int k = 2; k < fr_cnt && k < 16; k++)
            if (fr_len[k] != 2 || fr_byte[k][0] != 8'h05 || fr_byte[k][1] != 8'h00) bad_polls++;
        chk(bad_polls == 0, "R4", "malformed poll frames", bad_polls, 0);
        chk(min_gap >= CS_GAP, "R7", "min chip-select gap", min_gap, CS_GAP);
        chk(mosi_bad == 0, "R6", "mosi changes while sclk high", mosi_bad, 0);
    endtask

    task automatic run_vec(input logic [23:0] a, input int polls, input logic [1:0] exp_err);
        int cyc;
        poll_budget = polls;
        log_epoch++;
        pulse_req(a);
        if (exp_err == 2'd1) begin
            chk(done && err_code == 2'd1, "R1", "reject pulse next cycle", {done, err_code}, 3'b101);
            chk(!busy, "R1", "busy on reject", busy, 0);
            repeat (20) @(negedge clk);
            chk(fr_cnt == 0 && spi_cs_n, "R1", "frames on reject", fr_cnt, 0);
        end else begin
            chk(busy && !done, "R9", "busy after accept", {busy, done}, 2'b10);
            wait_done(cyc);
            chk(done, "R5", "done reached", done, 1);
            chk(err_code == 2'd0, "R5", "success code", err_code, 0);
            chk(!busy, "R9", "busy in done cycle", busy, 0);
            @(negedge clk);
            chk(!done, "R9", "done width", done, 0);
            repeat (CS_GAP + 4) @(negedge clk);
            chk(fr_cnt == polls + 3, "R5", "no frame after done", fr_cnt, polls + 3);
            check_frames(a, polls);
        end
    endtask

    // ---- watchdog
    initial begin
        wait (cycles >= 150000);
        n_errs++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    // ---- main sequence
    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && err_code == 2'd0, "R10", "reset state",
            {spi_cs_n, spi_sclk, busy, done, err_code}, 6'b100000);

        for (int v = 0; v < NV; v++)
            run_vec(VEC[v][33:10], int'(VEC[v][9:2]), VEC[v][1:0]);

        // R8: requests during an erase are ignored
        poll_budget = 2;
        log_epoch++;
        pulse_req(24'h002000);
        repeat (60) @(negedge clk);
        pulse_req(24'h005000);
        repeat (10) @(negedge clk);
        pulse_req(24'h000010);
        chk(!(done && err_code != 2'd0), "R8", "error while busy", err_code, 0);
        wait_done(cyc);
        chk(done && err_code == 2'd0, "R8", "single clean done", {done, err_code}, 3'b100);
        repeat (CS_GAP + 4) @(negedge clk);
        chk(done_cnt == 1, "R8", "done count", done_cnt, 1);
        check_frames(24'h002000, 2);

        // R10: reset in the middle of an erase
        poll_budget = 4;
        log_epoch++;
        pulse_req(24'h7A0000);
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && err_code == 2'd0, "R10", "state after mid-erase reset",
            {spi_cs_n, spi_sclk, busy, done, err_code}, 6'b100000);
        repeat (CS_GAP + 2) @(negedge clk);
        run_vec(24'h7A0000, 1, 2'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule